// File: doc/BRIEF.md
# Packed Grayscale Pixel Mapper

This block is a streaming stage that rewrites every 8-bit grayscale pixel of a stream on its own, without looking at any neighbour. Several pixels travel side by side in one data word. The output stream has the same shape as the input: the same word width, the same lane positions and the same end-of-frame marking.

Two mappings are available. The negative mapping reflects each pixel about full scale. The brightness mapping adds a signed offset to each pixel and clamps the result to the pixel range.

The mapping selector and the offset are quasi-static inputs. The stage captures them once per frame, on the first word of that frame, so a change in the middle of a frame cannot tear the picture. Both sides use a valid/ready handshake. A single output register gives one cycle of latency and keeps a rate of one word per cycle.

Top module: `pix_point_map`

## Requirements
- R1: While `rst_ni` is low and on the first sampling after reset, `m_valid_o` is 0 and `s_ready_o` is 1.
- R2: With `mode_i` = 1 (negative), each output pixel equals 255 minus the input pixel in the same lane.
- R3: With `mode_i` = 0 (brightness), each output pixel equals the input pixel plus `bias_i`, read as an 8-bit two's-complement value, whenever that sum lies in 0..255.
- R4: In brightness mode, a sum above 255 gives 255.
- R5: In brightness mode, a sum below 0 gives 0.
- R6: Lane k sits in bits [8k+7:8k], with lane 0 as the least significant byte. Each lane is mapped on its own and keeps its position on output. One word may hold clamped and unclamped lanes together.
- R7: `mode_i` and `bias_i` are captured on the first accepted word of a frame. A frame starts at the first accepted word after reset, or after a word accepted with `s_last_i` = 1. Changes to these inputs later in the frame have no effect until the next frame.
- R8: A word accepted on clock edge k appears on `m_data_o` with `m_valid_o` = 1 right after edge k. Its `s_last_i` appears on `m_last_o` with it. `m_valid_o` rises only for accepted words.
- R9: While `m_valid_o` = 1 and `m_ready_i` = 0, `m_valid_o`, `m_data_o` and `m_last_o` stay unchanged.
- R10: `s_ready_o` is 1 whenever `m_valid_o` = 0 or `m_ready_i` = 1, so one word passes per cycle when both sides are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Mapping select: 1 negative, 0 brightness |
| bias_i | input | 8 | Signed brightness offset |
| s_data_i | input | DATA_W | Packed input pixels |
| s_valid_i | input | 1 | Input word valid |
| s_last_i | input | 1 | Input word ends the frame |
| s_ready_o | output | 1 | Stage can accept a word |
| m_data_o | output | DATA_W | Packed output pixels |
| m_valid_o | output | 1 | Output word valid |
| m_last_o | output | 1 | Output word ends the frame |
| m_ready_i | input | 1 | Downstream accepts the word |

## Verification
Two events can fall in the same cycle: a new word is accepted while the held word drains, and a frame-start capture of the configuration happens while the output is backpressured. The bench provokes both by toggling `m_ready_i` and `s_valid_i` at random across several short frames. It also changes `mode_i` and `bias_i` at random times, including on frame boundaries. A behavioural model tracks the frame start, the captured settings and the output register. Ready, valid, data and last are then compared against that model on every clock.

// File: rtl/pix_map_pkg.sv
package pix_map_pkg;
  typedef enum logic {
    MAP_BRIGHT = 1'b0,
    MAP_NEG    = 1'b1
  } map_op_e;
endpackage

// File: rtl/pix_frame_cfg.sv
// Captures the mapping settings on the first accepted word of each frame.
module pix_frame_cfg #(
  parameter int PIX_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         accept_i,
  input  logic                         last_i,
  input  logic                         mode_i,
  input  logic [PIX_W-1:0]             bias_i,
  output pix_map_pkg::map_op_e         op_o,
  output logic [PIX_W-1:0]             bias_o
);
  import pix_map_pkg::*;

  logic             sof_q;
  map_op_e          op_q;
  logic [PIX_W-1:0] bias_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_q  <= 1'b1;
      op_q   <= MAP_BRIGHT;
      bias_q <= '0;
    end else if (accept_i) begin
      sof_q <= last_i;
      if (sof_q) begin
        op_q   <= map_op_e'(mode_i);
        bias_q <= bias_i;
      end
    end
  end

  // first word of a frame uses the live settings, later words the captured ones
  assign op_o   = sof_q ? map_op_e'(mode_i) : op_q;
  assign bias_o = sof_q ? bias_i : bias_q;
endmodule

// File: rtl/pix_lane_map.sv
module pix_lane_map #(
  parameter int PIX_W = 8
) (
  input  pix_map_pkg::map_op_e op_i,
  input  logic [PIX_W-1:0]     bias_i,
  input  logic [PIX_W-1:0]     pix_i,
  output logic [PIX_W-1:0]     pix_o
);
  import pix_map_pkg::*;

  localparam int SUM_W = PIX_W + 2;

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed({2'b00, pix_i}) + $signed({{2{bias_i[PIX_W-1]}}, bias_i});
    if (op_i == MAP_NEG) begin
      pix_o = ~pix_i;
    end else if (sum[SUM_W-1]) begin
      pix_o = '0;
    end else if (sum[PIX_W]) begin
      pix_o = '1;
    end else begin
      pix_o = sum[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/pix_out_reg.sv
module pix_out_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  input  logic         in_last_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         out_last_o,
  input  logic         out_ready_i
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_data_o <= in_data_i;
        out_last_o <= in_last_i;
      end
    end
  end
endmodule

// File: rtl/pix_point_map.sv
module pix_point_map #(
  parameter int DATA_W = 32,
  parameter int PIX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [PIX_W-1:0]  bias_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_valid_o,
  output logic              m_last_o,
  input  logic              m_ready_i
);
  import pix_map_pkg::*;

  localparam int LANES = DATA_W / PIX_W;

  logic              accept;
  map_op_e           op;
  logic [PIX_W-1:0]  bias;
  logic [DATA_W-1:0] mapped;

  assign accept = s_valid_i && s_ready_o;

  pix_frame_cfg #(.PIX_W(PIX_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .last_i   (s_last_i),
    .mode_i   (mode_i),
    .bias_i   (bias_i),
    .op_o     (op),
    .bias_o   (bias)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pix_lane_map #(.PIX_W(PIX_W)) u_lane (
      .op_i   (op),
      .bias_i (bias),
      .pix_i  (s_data_i[g*PIX_W +: PIX_W]),
      .pix_o  (mapped[g*PIX_W +: PIX_W])
    );
  end

  pix_out_reg #(.W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (s_valid_i),
    .in_data_i   (mapped),
    .in_last_i   (s_last_i),
    .in_ready_o  (s_ready_o),
    .out_valid_o (m_valid_o),
    .out_data_o  (m_data_o),
    .out_last_o  (m_last_o),
    .out_ready_i (m_ready_i)
  );
endmodule

// File: rtl/pix_point_map_chk.sv
module pix_point_map_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_valid_i,
  input logic              s_last_i,
  input logic              s_ready_o,
  input logic [DATA_W-1:0] m_data_o,
  input logic              m_valid_o,
  input logic              m_last_o,
  input logic              m_ready_i
);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));

  p_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> m_valid_o);

  p_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> (m_last_o == $past(s_last_i)));

  p_no_phantom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(s_valid_i && s_ready_o) && !(m_valid_o && !m_ready_i)) |=> !m_valid_o);

  p_flow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_ready_i |-> s_ready_o);
endmodule

bind pix_point_map pix_point_map_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .s_valid_i (s_valid_i),
  .s_last_i  (s_last_i),
  .s_ready_o (s_ready_o),
  .m_data_o  (m_data_o),
  .m_valid_o (m_valid_o),
  .m_last_o  (m_last_o),
  .m_ready_i (m_ready_i)
);

// File: tb/tb_pix_point_map.sv
`timescale 1ns/1ps
module tb_pix_point_map;
  localparam int DW = 32;
  localparam int NL = DW / 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_i = 1'b0;
  logic [7:0]    bias_i = '0;
  logic [DW-1:0] s_data_i = '0;
  logic          s_valid_i = 1'b0;
  logic          s_last_i = 1'b0;
  logic          s_ready_o;
  logic [DW-1:0] m_data_o;
  logic          m_valid_o;
  logic          m_last_o;
  logic          m_ready_i = 1'b1;

  always #4 clk_i = ~clk_i;

  pix_point_map #(.DATA_W(DW), .PIX_W(8)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit rnd_ready = 0;

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          mv = 0, ml = 0, sof = 1, c_mode = 0;
  logic [DW-1:0] md = '0;
  int          c_bias = 0;
  string       mtag = "R3";

  function automatic logic [DW-1:0] ref_map(logic [DW-1:0] w, bit neg, int b, output string tag);
    logic [DW-1:0] r;
    tag = neg ? "R2" : "R3";
    for (int k = 0; k < NL; k++) begin
      int v;
      v = int'(w[8*k +: 8]);
      if (neg) v = 255 - v;
      else begin
        v = v + b;
        if (v > 255) begin v = 255; tag = "R4"; end
        if (v < 0)   begin v = 0;   tag = "R5"; end
      end
      r[8*k +: 8] = 8'(v);
    end
    return r;
  endfunction

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      mv = 0; sof = 1;
    end else begin
      bit acc;
      check("R10 ready", s_ready_o, !mv || m_ready_i);
      check("R8 valid", m_valid_o, mv);
      if (mv) begin
        check({mtag, " data"}, m_data_o, md);
        check("R8 last", m_last_o, ml);
      end
      acc = s_valid_i && s_ready_o;
      if (acc) begin
        if (sof) begin c_mode = mode_i; c_bias = int'($signed(bias_i)); end
        sof = s_last_i;
        md = ref_map(s_data_i, c_mode, c_bias, mtag);
        ml = s_last_i;
        mv = 1;
      end else if (m_ready_i) mv = 0;
    end
  end

  always @(posedge clk_i) if (rnd_ready) #1 m_ready_i <= ($urandom_range(0, 2) != 0);

  task automatic send(logic [DW-1:0] d, bit last);
    bit acc;
    s_valid_i = 1; s_data_i = d; s_last_i = last;
    do begin
      @(negedge clk_i); acc = s_ready_o;
      @(posedge clk_i); #1;
    end while (!acc);
    s_valid_i = 0;
  endtask

  task automatic send_chk(string tag, logic [DW-1:0] d, bit last, logic [DW-1:0] exp);
    send(d, last);
    @(negedge clk_i);
    check(tag, m_data_o, exp);
    @(posedge clk_i); #1;
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", m_valid_o, 0);
    check("R1 ready in reset", s_ready_o, 1);
    @(posedge clk_i); #1 rst_ni = 1;
    @(negedge clk_i);
    check("R1 valid after reset", m_valid_o, 0);
    @(posedge clk_i); #1;

    mode_i = 1;
    send_chk("R2 negative", 32'h00FF5AA5, 0, 32'hFF00A55A);
    send_chk("R2 negative", 32'h12345678, 1, 32'hEDCBA987);

    mode_i = 0; bias_i = 8'd100;
    send_chk("R6 mixed lanes R4", 32'h00FFC010, 1, 32'h64FFFF74);
    bias_i = 8'h9C;
    send_chk("R5 low clamp R6", 32'h80646305, 1, 32'h1C000000);
    bias_i = 8'd7;
    send_chk("R3 in range", 32'h0A141E28, 1, 32'h111B252F);

    bias_i = 8'd1;
    send_chk("R7 first beat", 32'h01010101, 0, 32'h02020202);
    bias_i = 8'h10; mode_i = 1;
    send_chk("R7 mid-frame ignored", 32'h01010101, 1, 32'h02020202);
    mode_i = 0;
    send_chk("R7 next frame", 32'h01010101, 1, 32'h11111111);

    rnd_ready = 1;
    for (int f = 0; f < 60; f++) begin
      int len = $urandom_range(1, 6);
      for (int b = 0; b < len; b++) begin
        if ($urandom_range(0, 3) == 0) begin mode_i = $urandom_range(0, 1); bias_i = 8'($urandom); end
        if ($urandom_range(0, 2) == 0) begin @(posedge clk_i); #1; end
        send(DW'($urandom), b == len - 1);
      end
    end
    rnd_ready = 0;
    #1 m_ready_i = 1;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule